// File: doc/BRIEF.md
# Capture-Compare Timer with Toggle Output

This block is a 16-bit up-counter that advances on prescaler ticks and carries two compare registers, two capture registers and one output flip-flop. The counter steps by one on every clock edge where the run enable and the tick input are both high. When the counter steps onto a compare value, a one-cycle interrupt pulse is raised. A capture register takes a snapshot of the counter on a chosen hardware event or on a software command.

The output flip-flop drives `tmr_out`. Each of the four events can invert it under its own enable bit. The four events are the two compare matches and the two capture loads. Software can also toggle, set or clear it directly through a command register. The flip-flop has no guaranteed value after reset, so software must set or clear it before relying on it.

All configuration goes through a synchronous write port and a combinational read port, addressed by a 3-bit register index. The control register is at index 0. In it, bits 1:0 select the capture mode, bit 2 is the software-capture strobe (active when written as 0), and bits 6:3 are the inversion enables.

Top module: `tcc_timer`

## Requirements
- R1: The counter (read at index 6) increases by one on each clock edge where `run` and `tick` are both 1, and wraps from 0xFFFF to 0x0000. It holds its value on every other edge.
- R2: When the counter steps onto the value of compare register 0 (index 2) or compare register 1 (index 3), `irq` is 1 for the next cycle, which is the cycle in which the counter shows the matching value. A compare value that the counter does not step onto causes no match.
- R3: Control bits 1:0 select the capture mode. With 00, no hardware event loads a capture register. With 01, a rising edge of `cap_in` loads capture register 0 (index 4) with the counter value held at that clock edge. A rising edge means 0 at the previous edge and 1 now.
- R4: With mode 10, a rising edge of `cap_in` loads capture register 0 and a falling edge loads capture register 1 (index 5), each with the counter value held at that edge.
- R5: With mode 11, capture register 1 is loaded on the edge that ends the `irq` cycle caused by a compare-1 match, so it holds the compare-1 value.
- R6: Writing the control register with bit 2 at 0 while `run` is 1 loads capture register 0 with the counter value held at that edge. The same write while `run` is 0 leaves capture register 0 unchanged, and a write with bit 2 at 1 never captures.
- R7: Control bits 3, 4, 5 and 6 enable inversion of `tmr_out` by, in that order, a compare-0 match, a compare-1 match, a capture-0 load and a capture-1 load. An event whose enable is 0 leaves `tmr_out` unchanged.
- R8: When several enabled events fall on the same edge, `tmr_out` inverts once per event, so two such events leave it unchanged.
- R9: A write to index 1 acts on `tmr_out` through bits 1:0: 00 toggles it, 01 sets it and 10 clears it. The command takes effect at that edge and overrides any hardware inversion on the same edge. Command 11 has no effect.
- R10: `rd_data` follows `rd_addr` within the cycle. Index 0 returns the enables in bits 6:3, a constant 1 in bit 2 and the mode in bits 1:0. Index 1 returns `tmr_out` in bit 0. Indexes 2 to 6 return the compare, capture and counter values.
- R11: After reset the counter and both capture registers are 0, both compare registers are 0xFFFF, the control register reads 0x0004 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Prescaler run enable |
| tick | input | 1 | Prescaler tick, one count per high cycle while running |
| cap_in | input | 1 | External capture source, already synchronised |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| irq | output | 1 | One-cycle pulse per compare match |
| tmr_out | output | 1 | Output flip-flop state |

## Verification
Two pairs of functions can land on the same edge. The first pair is the two compare matches, when both compare registers hold the same value and both match enables are set. The second pair is a software flip-flop command and a hardware match inversion. The bench provokes both by writing the compare registers relative to the counter's known position, and by issuing the command write exactly on the edge where the counter reaches the compare value. In each case a behavioural model, updated every clock, judges the outcome, and explicit checks confirm that `tmr_out` is unchanged in the first case and cleared in the second.

// File: rtl/tcc_pkg.sv
// Shared constants and types for the capture-compare timer.
// Assumes a 3-bit register index; the data width is set by the top module.
package tcc_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_FFCMD = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP1  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP0  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAP1  = 3'd5;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd6;

    typedef enum logic [1:0] {
        CAPM_OFF    = 2'b00,
        CAPM_RISE   = 2'b01,
        CAPM_BOTH   = 2'b10,
        CAPM_MATCH1 = 2'b11
    } capm_e;

    typedef enum logic [1:0] {
        FF_TOGGLE = 2'b00,
        FF_SET    = 2'b01,
        FF_CLEAR  = 2'b10,
        FF_KEEP   = 2'b11
    } ffcmd_e;
endpackage

// File: rtl/tcc_counter.sv
// Free-running up-counter with NCMP equality comparators.
// A match is flagged in the cycle the counter steps onto a compare value,
// so each arrival produces exactly one event. Assumes adv is run & tick.
module tcc_counter #(
    parameter int W    = 16,
    parameter int NCMP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [W-1:0]     cmp [NCMP],
    output logic [W-1:0]     cnt,
    output logic [NCMP-1:0]  match
);
    logic [W-1:0] cnt_nxt;

    // next counter value, wrapping naturally at the width
    assign cnt_nxt = cnt + W'(1);

    // counter register: step on advance, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= cnt_nxt;
    end

    // one comparator per compare register, against the arriving value
    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        assign match[k] = adv && (cnt_nxt == cmp[k]);
    end
endmodule

// File: rtl/tcc_capture.sv
// Two capture registers with edge detection on the external source.
// Mode selects hardware loads; a software strobe always may load register 0.
// Assumes cap_in is already synchronous to clk.
module tcc_capture #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          cap_in,
    input  logic          sw_cap,
    input  logic          match1,
    input  logic [W-1:0]  cnt,
    output logic [W-1:0]  cap0,
    output logic [W-1:0]  cap1,
    output logic [1:0]    load
);
    import tcc_pkg::*;

    logic cap_in_q;
    logic m1_q;
    logic rise;
    logic fall;

    // remember last source level and delay the compare-1 match by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_in_q <= 1'b0;
            m1_q     <= 1'b0;
        end else begin
            cap_in_q <= cap_in;
            m1_q     <= match1;
        end
    end

    assign rise = cap_in & ~cap_in_q;
    assign fall = ~cap_in & cap_in_q;

    // decide which capture registers load on this edge
    always_comb begin
        load[0] = sw_cap | (rise & ((mode == CAPM_RISE) | (mode == CAPM_BOTH)));
        load[1] = (fall & (mode == CAPM_BOTH)) | (m1_q & (mode == CAPM_MATCH1));
    end

    // capture registers take the counter value held at the edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap0 <= '0;
            cap1 <= '0;
        end else begin
            if (load[0]) cap0 <= cnt;
            if (load[1]) cap1 <= cnt;
        end
    end
endmodule

// File: rtl/tcc_outff.sv
// Output flip-flop: inverts once per enabled event (parity of the enabled
// events), unless a software command on the same edge overrides it.
// Assumes cmd_vld is never raised for the no-effect command.
module tcc_outff #(
    parameter int NEV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEV-1:0]  ev,
    input  logic [NEV-1:0]  en,
    input  logic            cmd_vld,
    input  logic [1:0]      cmd,
    output logic            q
);
    import tcc_pkg::*;

    logic flip;

    // odd number of enabled events means one net inversion
    assign flip = ^(ev & en);

    // flip-flop update: software command first, else hardware parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (cmd_vld) begin
            case (ffcmd_e'(cmd))
                FF_TOGGLE: q <= ~q;
                FF_SET:    q <= 1'b1;
                FF_CLEAR:  q <= 1'b0;
                default:   q <= q;
            endcase
        end else if (flip) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/tcc_timer.sv
// Capture-compare timer top: register file, read mux and interrupt pulse
// around the counter, capture and output flip-flop units.
// Assumes W >= 8 so the control fields fit in the data word.
module tcc_timer #(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      tick,
    input  logic                      cap_in,
    input  logic                      wr_en,
    input  logic [tcc_pkg::ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]              wr_data,
    input  logic [tcc_pkg::ADDR_W-1:0] rd_addr,
    output logic [W-1:0]              rd_data,
    output logic                      irq,
    output logic                      tmr_out
);
    import tcc_pkg::*;

    localparam int NCMP = 2;
    localparam int NEV  = 2 * NCMP;

    logic [1:0]       mode_q;
    logic [NEV-1:0]   ten_q;
    logic [W-1:0]     cmp_q [NCMP];
    logic [W-1:0]     cnt_w;
    logic [W-1:0]     cap0_w;
    logic [W-1:0]     cap1_w;
    logic [NCMP-1:0]  match_w;
    logic [1:0]       load_w;
    logic             adv;
    logic             wr_ctrl;
    logic             sw_cap;
    logic             cmd_vld;
    logic             irq_q;

    assign adv     = run & tick;
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign sw_cap  = wr_ctrl && !wr_data[2] && run;
    assign cmd_vld = wr_en && (wr_addr == A_FFCMD) && (wr_data[1:0] != FF_KEEP);

    // control register: capture mode and inversion enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CAPM_OFF;
            ten_q  <= '0;
        end else if (wr_ctrl) begin
            mode_q <= wr_data[1:0];
            ten_q  <= wr_data[3 +: NEV];
        end
    end

    // compare registers, one per comparator
    for (genvar k = 0; k < NCMP; k++) begin : g_cmpreg
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_q[k] <= '1;
            else if (wr_en && (wr_addr == A_CMP0 + ADDR_W'(k)))
                cmp_q[k] <= wr_data;
        end
    end

    tcc_counter #(.W(W), .NCMP(NCMP)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .cmp   (cmp_q),
        .cnt   (cnt_w),
        .match (match_w)
    );

    tcc_capture #(.W(W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_q),
        .cap_in (cap_in),
        .sw_cap (sw_cap),
        .match1 (match_w[1]),
        .cnt    (cnt_w),
        .cap0   (cap0_w),
        .cap1   (cap1_w),
        .load   (load_w)
    );

    tcc_outff #(.NEV(NEV)) u_ff (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      ({load_w, match_w}),
        .en      (ten_q),
        .cmd_vld (cmd_vld),
        .cmd     (wr_data[1:0]),
        .q       (tmr_out)
    );

    // interrupt pulse, one cycle after any match
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |match_w;
    end

    assign irq = irq_q;

    // combinational register read
    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = W'({ten_q, 1'b1, mode_q});
            A_FFCMD: rd_data = W'(tmr_out);
            A_CMP0:  rd_data = cmp_q[0];
            A_CMP1:  rd_data = cmp_q[1];
            A_CAP0:  rd_data = cap0_w;
            A_CAP1:  rd_data = cap1_w;
            A_COUNT: rd_data = cnt_w;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tcc_chk.sv
// Property checker for the capture-compare timer, bound to the top module.
// Observes ports plus the counter value, capture mode and capture register 1.
module tcc_chk #(
    parameter int W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       run,
    input logic                       tick,
    input logic                       wr_en,
    input logic [tcc_pkg::ADDR_W-1:0] wr_addr,
    input logic [W-1:0]               wr_data,
    input logic                       irq,
    input logic                       tmr_out,
    input logic [W-1:0]               cnt,
    input logic [1:0]                 mode,
    input logic [W-1:0]               cap1
);
    import tcc_pkg::*;

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick) |=> $stable(cnt));

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (cnt == $past(cnt) + W'(1)));

    // R2
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(run && tick));

    // R9
    ff_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FFCMD && wr_data[1:0] == 2'b01) |=> tmr_out);

    // R9
    ff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FFCMD && wr_data[1:0] == 2'b10) |=> !tmr_out);

    // R3
    cap1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> $stable(cap1));
endmodule

bind tcc_timer tcc_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq     (irq),
    .tmr_out (tmr_out),
    .cnt     (cnt_w),
    .mode    (mode_q),
    .cap1    (cap1_w)
);

// File: tb/tcc_timer_test.sv
// Self-checking bench: a behavioural model updated on every clock edge is
// compared with the outputs each cycle, plus directed checks per requirement.
module tcc_timer_test;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        tick = 1'b0;
    logic        cap_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic        tmr_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  chk_on = 0;
    bit  tick_alt = 0;

    // model state
    logic [15:0] m_cnt, m_cmp0, m_cmp1, m_cap0, m_cap1;
    logic [1:0]  m_mode;
    logic [3:0]  m_en;
    logic        m_ff, m_irq, m_m1q, m_capq, m_known;

    tcc_timer uut (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cap_in(cap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .tmr_out(tmr_out)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return {9'd0, m_en, 1'b1, m_mode};
            3'd1: return {15'd0, m_ff};
            3'd2: return m_cmp0;
            3'd3: return m_cmp1;
            3'd4: return m_cap0;
            3'd5: return m_cap1;
            3'd6: return m_cnt;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd2, 3'd3: return "R10";
            3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R1";
            default: return "R10";
        endcase
    endfunction

    // behavioural model, one step per clock edge
    always @(posedge clk) begin : model
        int n;
        logic adv, m0, m1, rise, fall, c0, c1, swc;
        logic [15:0] nx;
        if (!rst_n) begin
            m_cnt = 0; m_cmp0 = 16'hFFFF; m_cmp1 = 16'hFFFF;
            m_cap0 = 0; m_cap1 = 0; m_mode = 0; m_en = 0;
            m_ff = 0; m_irq = 0; m_m1q = 0; m_capq = 0; m_known = 0;
        end else begin
            adv  = run && tick;
            nx   = m_cnt + 16'd1;
            m0   = adv && (nx == m_cmp0);
            m1   = adv && (nx == m_cmp1);
            rise = cap_in && !m_capq;
            fall = !cap_in && m_capq;
            swc  = wr_en && wr_addr == 3'd0 && !wr_data[2] && run;
            c0   = swc || (rise && (m_mode == 2'd1 || m_mode == 2'd2));
            c1   = (fall && m_mode == 2'd2) || (m_m1q && m_mode == 2'd3);
            if (c0) m_cap0 = m_cnt;
            if (c1) m_cap1 = m_cnt;
            n = int'(m0 && m_en[0]) + int'(m1 && m_en[1])
              + int'(c0 && m_en[2]) + int'(c1 && m_en[3]);
            if (wr_en && wr_addr == 3'd1 && wr_data[1:0] != 2'b11) begin
                case (wr_data[1:0])
                    2'b00: m_ff = !m_ff;
                    2'b01: begin m_ff = 1'b1; m_known = 1'b1; end
                    default: begin m_ff = 1'b0; m_known = 1'b1; end
                endcase
            end else if (n % 2 == 1) begin
                m_ff = !m_ff;
            end
            m_irq  = m0 || m1;
            m_m1q  = m1;
            m_capq = cap_in;
            if (adv) m_cnt = nx;
            if (wr_en && wr_addr == 3'd0) begin
                m_mode = wr_data[1:0];
                m_en   = wr_data[6:3];
            end
            if (wr_en && wr_addr == 3'd2) m_cmp0 = wr_data;
            if (wr_en && wr_addr == 3'd3) m_cmp1 = wr_data;
        end
    end

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (rst_n && chk_on) begin
            check("R2", {15'd0, irq}, {15'd0, m_irq});
            if (m_known) check("R7", {15'd0, tmr_out}, {15'd0, m_ff});
            check(tag_of(rd_addr), rd_data, m_rd(rd_addr));
        end
    end

    // alternating tick pattern when requested
    initial begin
        forever begin
            @(negedge clk);
            if (tick_alt) tick = ~tick;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            #2;
            if (irq) break;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] tgt, e0, e1;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;

        // R11: reset values
        for (int a = 0; a < 7; a++) begin
            if (a != 1) begin
                @(negedge clk);
                rd_addr = 3'(a);
                #2;
                check("R11", rd_data, (a == 0) ? 16'h0004 :
                                      (a == 2 || a == 3) ? 16'hFFFF : 16'h0000);
            end
        end
        check("R11", {15'd0, irq}, 16'h0000);

        // R9: software commands
        wr(3'd1, 16'h0001); #2; check("R9", {15'd0, tmr_out}, 16'h0001);
        wr(3'd1, 16'h0002); #2; check("R9", {15'd0, tmr_out}, 16'h0000);
        wr(3'd1, 16'h0000); #2; check("R9", {15'd0, tmr_out}, 16'h0001);
        wr(3'd1, 16'h0003); #2; check("R9", {15'd0, tmr_out}, 16'h0001);
        wr(3'd1, 16'h0000); #2; check("R9", {15'd0, tmr_out}, 16'h0000);

        // R1: counting, holding, uneven ticks, wrap
        rd_addr = 3'd6;
        run = 1'b1; tick = 1'b1;
        repeat (5) @(negedge clk);
        #2; check("R1", rd_data, 16'd5);
        run = 1'b0;
        repeat (3) @(negedge clk);
        #2; check("R1", rd_data, 16'd5);
        run = 1'b1; tick_alt = 1;
        repeat (10) @(negedge clk);
        #2; check("R1", rd_data, m_cnt);
        tick_alt = 0; tick = 1'b1;
        while (m_cnt != 16'hFFFF) @(negedge clk);
        @(negedge clk);
        #2; check("R1", rd_data, 16'h0000);

        // R2: compare-0 arrival raises irq with counter at the value
        tgt = m_cnt + 16'd12;
        wr(3'd2, tgt);
        wait_irq();
        check("R2", {15'd0, irq}, 16'h0001);
        check("R2", rd_data, tgt);

        // R7: compare-0 inversion enabled, compare-1 not
        wr(3'd1, 16'h0002);
        wr(3'd0, 16'h000C);
        tgt = m_cnt + 16'd12;
        wr(3'd2, tgt);
        wait_irq();
        check("R7", {15'd0, tmr_out}, 16'h0001);
        tgt = m_cnt + 16'd12;
        wr(3'd3, tgt);
        wait_irq();
        check("R7", {15'd0, tmr_out}, 16'h0001);

        // R8: both comparators match on one edge, both enabled
        wr(3'd0, 16'h001C);
        tgt = m_cnt + 16'd14;
        wr(3'd2, tgt);
        wr(3'd3, tgt);
        v = tmr_out;
        wait_irq();
        check("R8", {15'd0, tmr_out}, {15'd0, v});

        // R9: command on the same edge as an enabled match wins
        wr(3'd0, 16'h000C);
        wr(3'd1, 16'h0001);
        tgt = m_cnt + 16'd12;
        wr(3'd2, tgt);
        while (m_cnt != tgt - 16'd1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h0002;
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        check("R9", {15'd0, tmr_out}, 16'h0000);
        check("R2", {15'd0, irq}, 16'h0001);

        // R3: mode 01 rising edge loads capture 0
        wr(3'd0, 16'h0005);
        rd_addr = 3'd4;
        @(negedge clk); cap_in = 1'b1; e0 = m_cnt;
        @(negedge clk); #2; check("R3", rd_data, e0);
        cap_in = 1'b0;
        // R3: mode 00 ignores edges
        wr(3'd0, 16'h0004);
        @(negedge clk); cap_in = 1'b1;
        @(negedge clk); cap_in = 1'b0;
        @(negedge clk); #2; check("R3", rd_data, e0);
        rd_addr = 3'd5; #1; check("R3", rd_data, 16'h0000);

        // R4: mode 10 both edges, capture inversions enabled
        wr(3'd0, 16'h0066);
        @(negedge clk); cap_in = 1'b1; e0 = m_cnt;
        @(negedge clk); rd_addr = 3'd4; #2; check("R4", rd_data, e0);
        repeat (3) @(negedge clk);
        cap_in = 1'b0; e1 = m_cnt;
        @(negedge clk); rd_addr = 3'd5; #2; check("R4", rd_data, e1);

        // R5: mode 11 captures the compare-1 value
        wr(3'd0, 16'h0007);
        tgt = m_cnt + 16'd12;
        wr(3'd3, tgt);
        wait_irq();
        @(negedge clk); rd_addr = 3'd5; #2; check("R5", rd_data, tgt);

        // R6: software capture while running, ignored while stopped
        @(negedge clk);
        e0 = m_cnt;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0000;
        @(negedge clk);
        wr_en = 1'b0; rd_addr = 3'd4; #2; check("R6", rd_data, e0);
        run = 1'b0;
        repeat (2) @(negedge clk);
        wr(3'd0, 16'h0000); #2; check("R6", rd_data, e0);

        // R10: control readback and flip-flop readback
        wr(3'd0, 16'h0031);
        rd_addr = 3'd0; #2; check("R10", rd_data, 16'h0035);
        rd_addr = 3'd1; #2; check("R10", rd_data, {15'd0, tmr_out});

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule